// File: doc/BRIEF.md
# Triggered DMA Request Generator Channel

This block is a single channel of a trigger-driven DMA request source. It watches one of up to 32 trigger lines, chosen by a select field, and when the configured edge appears on that line it issues a burst of DMA requests. The number of requests per burst is programmed as a count minus one, so one trigger yields between 1 and 32 requests. Each request is held high until the DMA engine acknowledges it. The generated request line is meant to be offered to a request router as one more selectable input, with one router input per generator channel.

A trigger edge that arrives while a burst is still outstanding is not queued. It raises a sticky overrun flag and is otherwise dropped. Software clears the flag with a write-one-to-clear pulse. An interrupt line shows the flag gated by its own enable. Clearing the channel enable aborts any burst in progress. The flag is kept when this happens.

The control is a three-state machine. GEN_IDLE is the disabled state, and in it the burst length is loaded from the configuration. GEN_ARMED is enabled and waiting for a trigger edge. GEN_BURST drives the request and counts acknowledges. The named transitions are:
- enable: GEN_IDLE to GEN_ARMED, or straight to GEN_BURST if an edge is seen in that cycle.
- fire: GEN_ARMED to GEN_BURST on an edge.
- last_ack: GEN_BURST to GEN_ARMED on the acknowledge of the final request.
- abort: any state to GEN_IDLE when the enable is low.

Top module: `reqgen_channel`

## Requirements
- R1: During and right after reset, dma_req, ovr_flag and ovr_irq are 0.
- R2: cfg_edge selects the active trigger edge: 0 = none, 1 = rising, 2 = falling, 3 = both. When the channel is armed and the selected edge is sampled at a clock edge, dma_req is high from that clock edge on.
- R3: Only trigger line trig_in[cfg_trig_sel] is observed. Activity on any other trigger line has no effect on dma_req.
- R4: One trigger produces exactly cfg_count_m1+1 requests. dma_req stays high until a clock edge at which dma_ack is high. After the acknowledge of the last request, dma_req goes low.
- R5: The burst length is captured only while cfg_enable is 0. A change to cfg_count_m1 while the channel is enabled does not change the length of later bursts until the channel has been disabled again.
- R6: A selected trigger edge sampled during a burst sets ovr_flag at that clock edge. That trigger edge does not start or extend any burst.
- R7: A clock edge with ovr_clear high clears ovr_flag. If an overrun happens at the same clock edge, the set wins and the flag stays 1.
- R8: ovr_irq is high exactly when ovr_flag and cfg_ovr_irq_en are both high.
- R9: When cfg_enable is low at a clock edge, dma_req is low after that clock edge and any pending burst is discarded. ovr_flag keeps its value.
- R10: dma_ack has no effect while no request is pending: the next burst still has its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_trig_sel | input | 5 | Index of the observed trigger line |
| cfg_edge | input | 2 | Trigger edge code (0 none, 1 rise, 2 fall, 3 both) |
| cfg_count_m1 | input | 5 | Requests per trigger minus one |
| cfg_ovr_irq_en | input | 1 | Overrun interrupt enable |
| trig_in | input | 32 | Trigger lines, synchronous to clk |
| dma_ack | input | 1 | DMA acknowledge of the current request |
| ovr_clear | input | 1 | Write-one pulse that clears the overrun flag |
| dma_req | output | 1 | Generated DMA request |
| ovr_flag | output | 1 | Sticky trigger overrun flag |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The assertions assume the following about the inputs:
- trig_in is already synchronous to clk.
- dma_ack is a single-cycle pulse that answers a request that is high.
- cfg_trig_sel and cfg_edge are changed only while no edge of interest is expected.

The stimulus meets these assumptions by driving every input on the falling clock edge. It acknowledges only on cycles where it sees dma_req high. It changes the trigger select and the edge code only while the channel is idle and the trigger level is steady.

// File: rtl/reqgen_pkg.sv
package reqgen_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        GEN_IDLE  = 2'd0,
        GEN_ARMED = 2'd1,
        GEN_BURST = 2'd2
    } gen_state_e;

endpackage

// File: rtl/reqgen_edge.sv
module reqgen_edge
    import reqgen_pkg::*;
#(
    parameter int NUM_TRIG = 32,
    parameter int SEL_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]    sel,
    input  edge_mode_e          mode,
    output logic                edge_hit
);

    logic cur_lvl;
    logic prev_lvl_q;
    logic rise_w;
    logic fall_w;

    // Lines beyond NUM_TRIG read as a constant low level.
    always_comb begin
        cur_lvl = 1'b0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (int'(sel) == i) cur_lvl = trig_in[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl_q <= 1'b0;
        else        prev_lvl_q <= cur_lvl;
    end

    assign rise_w = cur_lvl & ~prev_lvl_q;
    assign fall_w = ~cur_lvl & prev_lvl_q;

    always_comb begin
        unique case (mode)
            EDGE_NONE: edge_hit = 1'b0;
            EDGE_RISE: edge_hit = rise_w;
            EDGE_FALL: edge_hit = fall_w;
            EDGE_BOTH: edge_hit = rise_w | fall_w;
            default:   edge_hit = 1'b0;
        endcase
    end

    // R2: an edge can only be reported when the sampled level moved.
    assert_edge_needs_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (prev_lvl_q != $past(prev_lvl_q)));

endmodule

// File: rtl/reqgen_burst.sv
module reqgen_burst
    import reqgen_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] count_m1,
    input  logic             edge_hit,
    input  logic             ack,
    output logic             req,
    output logic             ovr_evt
);

    gen_state_e       state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic [CNT_W-1:0] count_q;

    // The burst length is sampled only while the channel is disabled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_q <= '0;
        else if (!enable) count_q <= count_m1;
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            GEN_IDLE: begin
                if (enable && edge_hit) begin
                    state_d = GEN_BURST;
                    left_d  = count_q;
                end else if (enable) begin
                    state_d = GEN_ARMED;
                end
            end
            GEN_ARMED: begin
                if (!enable) begin
                    state_d = GEN_IDLE;
                end else if (edge_hit) begin
                    state_d = GEN_BURST;
                    left_d  = count_q;
                end
            end
            GEN_BURST: begin
                if (!enable) begin
                    state_d = GEN_IDLE;
                    left_d  = '0;
                end else if (ack) begin
                    if (left_q == '0) state_d = GEN_ARMED;
                    else              left_d  = left_q - 1'b1;
                end
            end
            default: begin
                state_d = GEN_IDLE;
                left_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        req     = (state_q == GEN_BURST);
        ovr_evt = (state_q == GEN_BURST) && enable && edge_hit;
    end

    // R4: a request is held until it is acknowledged.
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && enable) |=> req);
    // R9: disable drops the request at the next edge.
    assert_disable_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !req);
    // R5: the captured length does not move while enabled.
    assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(count_q));

endmodule

// File: rtl/reqgen_flag.sv
module reqgen_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R6: an overrun event leaves the flag set.
    assert_ovr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    // R7: a clear with no competing set empties the flag.
    assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/reqgen_channel.sv
module reqgen_channel
    import reqgen_pkg::*;
#(
    parameter int NUM_TRIG = 32,
    parameter int CNT_W    = 5,
    localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_enable,
    input  logic [SEL_W-1:0]    cfg_trig_sel,
    input  logic [1:0]          cfg_edge,
    input  logic [CNT_W-1:0]    cfg_count_m1,
    input  logic                cfg_ovr_irq_en,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                dma_ack,
    input  logic                ovr_clear,
    output logic                dma_req,
    output logic                ovr_flag,
    output logic                ovr_irq
);

    logic edge_hit;
    logic ovr_evt;

    reqgen_edge #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .sel      (cfg_trig_sel),
        .mode     (edge_mode_e'(cfg_edge)),
        .edge_hit (edge_hit)
    );

    reqgen_burst #(.CNT_W(CNT_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cfg_enable),
        .count_m1 (cfg_count_m1),
        .edge_hit (edge_hit),
        .ack      (dma_ack),
        .req      (dma_req),
        .ovr_evt  (ovr_evt)
    );

    reqgen_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (ovr_evt),
        .clr  (ovr_clear),
        .flag (ovr_flag)
    );

    assign ovr_irq = ovr_flag & cfg_ovr_irq_en;

    // R6: the flag only rises while a burst was being served.
    assert_flag_rise_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_flag && !dma_req) |=> !ovr_flag);

endmodule

// File: tb/reqgen_channel_tb_top.sv
module reqgen_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [4:0]  cfg_trig_sel = '0;
    logic [1:0]  cfg_edge = '0;
    logic [4:0]  cfg_count_m1 = '0;
    logic        cfg_ovr_irq_en = 1'b0;
    logic [31:0] trig = '0;
    logic        dma_ack = 1'b0;
    logic        ovr_clear = 1'b0;
    logic        dma_req, ovr_flag, ovr_irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    reqgen_channel dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_trig_sel(cfg_trig_sel),
        .cfg_edge(cfg_edge), .cfg_count_m1(cfg_count_m1), .cfg_ovr_irq_en(cfg_ovr_irq_en),
        .trig_in(trig), .dma_ack(dma_ack), .ovr_clear(ovr_clear),
        .dma_req(dma_req), .ovr_flag(ovr_flag), .ovr_irq(ovr_irq)
    );

    // Behavioural reference model
    bit m_prev, m_busy, m_flag;
    int m_left, m_cnt;

    always @(posedge clk) begin
        bit cur, r, f, e, ov;
        if (!rst_n) begin
            m_prev = 0; m_busy = 0; m_flag = 0; m_left = 0; m_cnt = 0;
        end else begin
            cur = trig[cfg_trig_sel];
            r = cur && !m_prev;
            f = !cur && m_prev;
            e = (cfg_edge == 2'd1) ? r : (cfg_edge == 2'd2) ? f : (cfg_edge == 2'd3) ? (r || f) : 1'b0;
            ov = 0;
            if (!cfg_enable) begin
                m_busy = 0; m_left = 0; m_cnt = cfg_count_m1;
            end else if (m_busy) begin
                if (e) ov = 1;
                if (dma_ack) begin
                    if (m_left == 0) m_busy = 0;
                    else m_left = m_left - 1;
                end
            end else if (e) begin
                m_busy = 1; m_left = m_cnt;
            end
            if (ov) m_flag = 1;
            else if (ovr_clear) m_flag = 0;
            m_prev = cur;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            check("R4 dma_req model", dma_req, m_busy);
            check("R6 ovr_flag model", ovr_flag, m_flag);
            check("R8 ovr_irq model", ovr_irq, m_flag && cfg_ovr_irq_en);
        end
    end

    task automatic step();
        @(posedge clk); #3;
        @(negedge clk);
    endtask

    // Serve a burst: ack on odd iterations, toggle trigger bit at t1/t2, clear at tc.
    task automatic serve(input int bitn, input int t1, input int t2, input int tc, output int n);
        n = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            ovr_clear = (i == tc);
            if (i == t1 || i == t2) trig[bitn] = ~trig[bitn];
            if (dma_req && (i % 2 == 1)) begin dma_ack = 1; n++; end
            else dma_ack = 0;
        end
        @(negedge clk);
        dma_ack = 0; ovr_clear = 0;
    endtask

    task automatic setup(input int sel, input int mode, input int cnt);
        @(negedge clk);
        cfg_enable = 0; cfg_trig_sel = 5'(sel); cfg_edge = 2'(mode); cfg_count_m1 = 5'(cnt);
        step();
        cfg_enable = 1;
        step();
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 req in reset", dma_req, 0);
        check("R1 flag in reset", ovr_flag, 0);
        rst_n = 1;
        step();
        check("R1 req after reset", dma_req, 0);
        check("R1 irq after reset", ovr_irq, 0);

        // R2 rising edge, R4 burst length 3
        setup(3, 1, 2);
        trig[3] = 1;
        @(posedge clk); #3;
        check("R2 rise starts burst", dma_req, 1);
        serve(3, -1, -1, -1, n);
        check("R4 burst of count+1", n, 3);
        check("R4 req low after burst", dma_req, 0);

        // R3 other lines ignored
        trig[5] = 1; step(); trig[5] = 0; step(); step();
        check("R3 unselected line ignored", dma_req, 0);

        // R2 falling mode: rise ignored, fall fires
        setup(3, 2, 0);
        trig[3] = 0;
        @(posedge clk); #3;
        check("R2 fall starts burst", dma_req, 1);
        serve(3, -1, -1, -1, n);
        check("R2 fall burst length", n, 1);
        trig[3] = 1; step(); step();
        check("R2 rise ignored in fall mode", dma_req, 0);

        // R2 both edges, none mode
        setup(3, 3, 1);
        trig[3] = 0;
        @(posedge clk); #3;
        check("R2 both-edge fires", dma_req, 1);
        serve(3, -1, -1, -1, n);
        check("R2 both-edge length", n, 2);
        setup(3, 0, 1);
        trig[3] = 1; step(); trig[3] = 0; step(); step();
        check("R2 none mode never fires", dma_req, 0);

        // R5 count change while enabled ignored
        setup(3, 1, 2);
        cfg_count_m1 = 5'd7; step();
        trig[3] = 1; step();
        serve(3, -1, -1, -1, n);
        check("R5 length held while enabled", n, 3);
        trig[3] = 0;
        setup(3, 1, 7);
        trig[3] = 1; step();
        serve(3, -1, -1, -1, n);
        check("R5 new length after disable", n, 8);

        // R6 overrun during burst, edge ignored; R8 irq gating
        trig[3] = 0; step();
        setup(3, 1, 3);
        trig[3] = 1; step();
        serve(3, 2, 4, -1, n);
        check("R6 overrun edge ignored", n, 4);
        check("R6 flag set", ovr_flag, 1);
        check("R8 irq masked", ovr_irq, 0);
        cfg_ovr_irq_en = 1; step();
        check("R8 irq enabled", ovr_irq, 1);

        // R7 clear, and set wins over clear
        ovr_clear = 1; step(); ovr_clear = 0; step();
        check("R7 flag cleared", ovr_flag, 0);
        trig[3] = 0; step();
        trig[3] = 1; step();
        serve(3, 2, 4, 4, n);
        check("R7 set beats clear", ovr_flag, 1);

        // R9 disable mid-burst keeps flag
        trig[3] = 0; step();
        trig[3] = 1; step();
        check("R9 burst running", dma_req, 1);
        cfg_enable = 0; step();
        check("R9 req dropped", dma_req, 0);
        check("R9 flag kept", ovr_flag, 1);

        // R10 ack while idle has no effect
        trig[3] = 0;
        setup(3, 1, 2);
        dma_ack = 1; step(); step(); dma_ack = 0; step();
        trig[3] = 1; step();
        serve(3, -1, -1, -1, n);
        check("R10 idle ack ignored", n, 3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule